// File: doc/BRIEF.md
# Serial EEPROM Bus Target

This block is the target side of a two-wire serial bus that presents itself as a byte-addressed EEPROM. It oversamples the clock and data lines with the system clock and detects START, STOP and clock edges. It decodes a device byte whose upper nibble is a fixed type code and whose next three bits carry the top address bits. It then takes two address bytes, stores the data bytes that follow, and streams bytes back out when the direction bit asks for a read. The data line is open-drain: the block only pulls it low, through an output-enable, and never drives it high.

The three high address bits in the device byte are matched against strap inputs. A mask parameter picks which of those bits take part in the match, so several devices can share one bus. Writes stay inside one page: the low pointer bits wrap and the page bits stay fixed. A STOP that ends a transfer with data starts a self-timed programming interval. During that interval the device refuses its own address, so a controller can poll with acknowledges until the device answers. Reads have no length limit and wrap at the top of the implemented array.

Top module: `i2c_eep_target`

## Requirements
- R1: After reset the target leaves SDA released (sda_oe low) and keeps it released while the bus is idle.
- R2: A device byte is accepted when bits 7:4 are 1010 and the masked bits 3:1 equal the masked strap_i. Bit 0 is the direction: 0 means write, 1 means read. The target acknowledges by pulling SDA low during the ninth clock.
- R3: A device byte that does not match is not acknowledged. SDA then stays released through every later clock until the next START.
- R4: Device byte bits whose CMP_MASK bit is 0 take no part in the match. With the default mask, only bit 3 (address bit 18) is compared, with strap_i[2], and bits 2:1 may hold any value.
- R5: In a write, the two bytes after the device byte set the pointer. The high byte comes first, then the low byte, and only the low MEM_AW bits are kept. Each later byte is acknowledged and stored at the pointer.
- R6: After each stored byte, the low PAGE_BITS bits of the pointer increment and wrap to the start of the page, while the page bits stay unchanged.
- R7: A STOP after at least one stored data byte starts a programming interval of WR_CYCLES clocks. During that interval every device byte gets no acknowledge. Once the interval ends, the device byte is acknowledged again.
- R8: A STOP after a write that carried only the address bytes starts no programming interval. The pointer keeps that address, so a later read returns data starting there.
- R9: In a read, bytes go out MSB first, starting at the pointer. The pointer increments by one per byte across page edges and wraps from 2^MEM_AW-1 to 0. Output continues while the controller acknowledges. A controller NACK ends the output, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data value to drive, always 0 (open drain) |
| sda_oe | output | 1 | Pull data line low when high |
| strap_i | input | 3 | Hardware address straps compared with device byte bits 3:1 |

## Verification
The end of the programming interval and the match decision on a polled device byte can land in the same clock. The busy flag drops in the same evaluation that accepts or refuses the address. The bench provokes this by polling back to back, right after the STOP that closes a write, so that one decision falls close to the expiry. It judges the result by the time from that STOP to the first acknowledged poll: this must be at least WR_CYCLES and at most one poll period more. It also checks that the first poll is refused and that the data written before the interval reads back intact.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_IGN
   } eep_state_e;

   typedef enum logic [1:0] {
      RB_DEV,
      RB_AHI,
      RB_ALO,
      RB_DATA
   } rx_role_e;

   localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_eep_bus_mon.sv
module i2c_eep_bus_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_sr;
   logic [SYNC_STAGES-1:0] sda_sr;
   logic                   scl_m;
   logic                   scl_q;
   logic                   sda_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
         sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
         scl_q  <= scl_m;
         sda_q  <= sda_s;
      end
   end

   assign scl_m     = scl_sr[SYNC_STAGES-1];
   assign sda_s     = sda_sr[SYNC_STAGES-1];
   assign scl_rise  = scl_m & ~scl_q;
   assign scl_fall  = ~scl_m & scl_q;
   assign start_det = scl_m & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_m & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_eep_wcycle.sv
module i2c_eep_wcycle #(
   parameter int unsigned CYCLES = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign busy_o = (cnt_q != '0);

   // R7: a started interval reports busy on the next clock
   a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

   // R7: the interval shrinks by exactly one per clock
   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/i2c_eep_mem.sv
module i2c_eep_mem #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/i2c_eep_target.sv
module i2c_eep_target
   import i2c_eep_pkg::*;
#(
   parameter int          MEM_AW      = 10,
   parameter int          PAGE_BITS   = 8,
   parameter int unsigned WR_CYCLES   = 1250000,
   parameter logic [2:0]  CMP_MASK    = 3'b100,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_o,
   output logic       sda_oe,
   input  logic [2:0] strap_i
);

   localparam int AHI_W = MEM_AW - 8;
   localparam logic [MEM_AW-1:0]    PTR_ONE  = MEM_AW'(1);
   localparam logic [PAGE_BITS-1:0] PAGE_ONE = PAGE_BITS'(1);
   localparam logic [3:0]           BIT_ONE  = 4'd1;
   localparam logic [3:0]           BIT_LAST = 4'd8;

   generate
      if (MEM_AW < 9 || MEM_AW > 16) begin : g_bad_aw
         $error("MEM_AW must lie in 9..16");
      end
      if (PAGE_BITS < 1 || PAGE_BITS >= MEM_AW) begin : g_bad_page
         $error("PAGE_BITS must lie in 1..MEM_AW-1");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, wc_start;

   eep_state_e        state_q;
   rx_role_e          role_q;
   logic [3:0]        bitcnt_q;
   logic [7:0]        rx_sh_q;
   logic [7:0]        tx_sh_q;
   logic [AHI_W-1:0]  ahi_q;
   logic [MEM_AW-1:0] ptr_q;
   logic              rw_q;
   logic              ack_q;
   logic              acked_q;
   logic              wrote_q;

   logic              byte_done;
   logic              dev_hit;
   logic              mem_we;
   logic [7:0]        rdata;
   logic [MEM_AW-1:0] ptr_page_nxt;

   i2c_eep_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_eep_wcycle #(.CYCLES(WR_CYCLES)) u_wcyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wc_start),
      .busy_o  (busy)
   );

   i2c_eep_mem #(.AW(MEM_AW), .DW(8)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (ptr_q),
      .wdata (rx_sh_q),
      .raddr (ptr_q),
      .rdata (rdata)
   );

   assign byte_done    = (state_q == ST_RX) && scl_fall && (bitcnt_q == BIT_LAST);
   assign dev_hit      = (rx_sh_q[7:4] == DEV_TYPE) &&
                         (((rx_sh_q[3:1] ^ strap_i) & CMP_MASK) == 3'b000) && !busy;
   assign mem_we       = byte_done && (role_q == RB_DATA);
   assign wc_start     = stop_det && wrote_q;
   assign ptr_page_nxt = {ptr_q[MEM_AW-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + PAGE_ONE};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         role_q   <= RB_DEV;
         bitcnt_q <= '0;
         rx_sh_q  <= '0;
         tx_sh_q  <= '0;
         ahi_q    <= '0;
         ptr_q    <= '0;
         rw_q     <= 1'b0;
         ack_q    <= 1'b0;
         acked_q  <= 1'b0;
         wrote_q  <= 1'b0;
      end else if (start_det) begin
         state_q  <= ST_RX;
         role_q   <= RB_DEV;
         bitcnt_q <= '0;
         ack_q    <= 1'b0;
      end else if (stop_det) begin
         state_q  <= ST_IDLE;
         ack_q    <= 1'b0;
         wrote_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_RX: begin
               if (scl_rise) begin
                  rx_sh_q  <= {rx_sh_q[6:0], sda_s};
                  bitcnt_q <= bitcnt_q + BIT_ONE;
               end
               if (byte_done) begin
                  bitcnt_q <= '0;
                  case (role_q)
                     RB_DEV: begin
                        if (dev_hit) begin
                           rw_q    <= rx_sh_q[0];
                           ack_q   <= 1'b1;
                           state_q <= ST_ACK;
                        end else begin
                           state_q <= ST_IGN;
                        end
                     end
                     RB_AHI: begin
                        ahi_q   <= rx_sh_q[AHI_W-1:0];
                        ack_q   <= 1'b1;
                        state_q <= ST_ACK;
                     end
                     RB_ALO: begin
                        ptr_q   <= {ahi_q, rx_sh_q};
                        ack_q   <= 1'b1;
                        state_q <= ST_ACK;
                     end
                     default: begin
                        ptr_q   <= ptr_page_nxt;
                        wrote_q <= 1'b1;
                        ack_q   <= 1'b1;
                        state_q <= ST_ACK;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  ack_q    <= 1'b0;
                  bitcnt_q <= '0;
                  if (role_q == RB_DEV && rw_q) begin
                     tx_sh_q <= rdata;
                     state_q <= ST_TX;
                  end else begin
                     state_q <= ST_RX;
                     case (role_q)
                        RB_DEV:  role_q <= RB_AHI;
                        RB_AHI:  role_q <= RB_ALO;
                        default: role_q <= RB_DATA;
                     endcase
                  end
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bitcnt_q <= bitcnt_q + BIT_ONE;
               end
               if (scl_fall) begin
                  if (bitcnt_q == BIT_LAST) begin
                     ptr_q   <= ptr_q + PTR_ONE;
                     state_q <= ST_TXACK;
                  end else begin
                     tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                  end
               end
            end
            ST_TXACK: begin
               if (scl_rise) begin
                  acked_q <= ~sda_s;
               end
               if (scl_fall) begin
                  if (acked_q) begin
                     tx_sh_q  <= rdata;
                     bitcnt_q <= '0;
                     state_q  <= ST_TX;
                  end else begin
                     state_q  <= ST_IGN;
                  end
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign sda_o  = 1'b0;
   assign sda_oe = ack_q | ((state_q == ST_TX) & ~tx_sh_q[7]);

   // R3: an ignored transaction never pulls the line
   a_r3_ign_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IGN) |-> !sda_oe);

   // R7: a device byte seen while programming is refused
   a_r7_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && role_q == RB_DEV && busy) |=> (!sda_oe && state_q == ST_IGN));

   // R6: storing a byte never moves the page bits of the pointer
   a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> $stable(ptr_q[MEM_AW-1:PAGE_BITS]));

   // R9: each transmitted byte advances the pointer by one
   a_r9_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TX && scl_fall && bitcnt_q == BIT_LAST) |=> (ptr_q == $past(ptr_q) + PTR_ONE));

   // R1: idle bus leaves the line released
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_oe);

endmodule

// File: tb/tb_i2c_eep_target.sv
module tb_i2c_eep_target;

   localparam int WRC = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_scl = 1'b1;
   logic ctl_sda = 1'b1;
   logic [2:0] strap = 3'b101;
   logic sda_o, sda_oe, sda_line;
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign sda_line = ctl_sda & ~(sda_oe & ~sda_o);

   i2c_eep_target #(
      .MEM_AW(10), .PAGE_BITS(8), .WR_CYCLES(WRC), .CMP_MASK(3'b100), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(ctl_scl), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic q();
      repeat (10) @(negedge clk);
   endtask

   task automatic bus_start();
      ctl_sda = 1'b1; q(); ctl_scl = 1'b1; q(); ctl_sda = 1'b0; q(); ctl_scl = 1'b0; q();
   endtask

   int stop_cyc;
   task automatic bus_stop();
      ctl_sda = 1'b0; q(); ctl_scl = 1'b1; q(); ctl_sda = 1'b1; stop_cyc = cyc; q();
   endtask

   task automatic clk_bit(input logic b, output logic r);
      ctl_sda = b; q(); ctl_scl = 1'b1; q(); r = sda_line; q(); ctl_scl = 1'b0; q();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
      clk_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic rd_byte(input logic ack_it, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, r);
         d[i] = r;
      end
      clk_bit(~ack_it, r);
   endtask

   task automatic set_ptr(input logic [15:0] a, output logic ok);
      logic a0, a1, a2;
      bus_start();
      wr_byte(8'hA8, a0);
      wr_byte(a[15:8], a1);
      wr_byte(a[7:0], a2);
      ok = a0 & a1 & a2;
   endtask

   task automatic poll_ready(output int tries);
      logic a;
      tries = 0;
      for (int k = 0; k < 40; k++) begin
         bus_start();
         wr_byte(8'hA8, a);
         bus_stop();
         tries++;
         if (a) break;
      end
   endtask

   logic [7:0] rbuf [8];
   task automatic read_from(input logic [15:0] a, input int n);
      logic ok, a0;
      set_ptr(a, ok);
      bus_start();
      wr_byte(8'hA9, a0);
      for (int i = 0; i < n; i++) rd_byte(i != n - 1, rbuf[i]);
      chk("R9 released after nack", {31'd0, sda_oe}, 32'd0);
      bus_stop();
   endtask

   task automatic write_seq(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input logic [7:0] d3, input int n);
      logic ok, ak;
      int t;
      logic [7:0] dv [4];
      dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
      set_ptr(a, ok);
      chk("R2 R5 address acks", {31'd0, ok}, 32'd1);
      for (int i = 0; i < n; i++) begin
         wr_byte(dv[i], ak);
         chk("R5 data ack", {31'd0, ak}, 32'd1);
      end
      bus_stop();
      poll_ready(t);
   endtask

   task automatic t_reset();
      chk("R1 released after reset", {31'd0, sda_oe}, 32'd0);
      repeat (50) @(negedge clk);
      chk("R1 released while idle", {31'd0, sda_oe}, 32'd0);
   endtask

   task automatic t_write_read();
      write_seq(16'h0123, 8'h11, 8'h22, 8'h33, 8'h00, 3);
      read_from(16'h0123, 3);
      chk("R5 R9 byte0", {24'd0, rbuf[0]}, 32'h11);
      chk("R5 R9 byte1", {24'd0, rbuf[1]}, 32'h22);
      chk("R5 R9 byte2", {24'd0, rbuf[2]}, 32'h33);
   endtask

   task automatic t_page_wrap();
      write_seq(16'h0100, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
      write_seq(16'h00FE, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 4);
      read_from(16'h0000, 2);
      chk("R6 wrapped to page start", {24'd0, rbuf[0]}, 32'hC3);
      chk("R6 wrapped second", {24'd0, rbuf[1]}, 32'hD4);
      read_from(16'h00FE, 3);
      chk("R6 page end byte", {24'd0, rbuf[0]}, 32'hA1);
      chk("R6 page end byte2", {24'd0, rbuf[1]}, 32'hB2);
      chk("R6 R9 next page untouched", {24'd0, rbuf[2]}, 32'h5A);
   endtask

   task automatic t_busy();
      logic ok, ak, a;
      int t0, t, dt;
      set_ptr(16'h0200, ok);
      wr_byte(8'h66, ak);
      bus_stop();
      t0 = stop_cyc;
      bus_start();
      wr_byte(8'hA8, a);
      bus_stop();
      chk("R7 first poll refused", {31'd0, a}, 32'd0);
      poll_ready(t);
      dt = cyc - t0;
      chk("R7 ready not early", {31'd0, dt >= WRC}, 32'd1);
      chk("R7 ready not late", {31'd0, dt <= WRC + 1000}, 32'd1);
      read_from(16'h0200, 1);
      chk("R7 data intact", {24'd0, rbuf[0]}, 32'h66);
   endtask

   task automatic t_no_busy();
      logic ok, a;
      set_ptr(16'h0124, ok);
      bus_stop();
      bus_start();
      wr_byte(8'hA9, a);
      chk("R8 no interval after address-only write", {31'd0, a}, 32'd1);
      rd_byte(1'b0, rbuf[0]);
      bus_stop();
      chk("R8 pointer kept", {24'd0, rbuf[0]}, 32'h22);
   endtask

   task automatic t_mismatch();
      logic a, b;
      logic [7:0] d;
      bus_start();
      wr_byte(8'hB8, a);
      chk("R3 wrong type refused", {31'd0, a}, 32'd0);
      wr_byte(8'h00, b);
      chk("R3 later byte refused", {31'd0, b}, 32'd0);
      bus_stop();
      bus_start();
      wr_byte(8'hA1, a);
      chk("R3 strap mismatch refused", {31'd0, a}, 32'd0);
      rd_byte(1'b1, d);
      chk("R3 line released in read", {24'd0, d}, 32'hFF);
      bus_stop();
   endtask

   task automatic t_mask();
      logic ok, ak, a;
      int t;
      bus_start();
      wr_byte(8'hAC, ok);
      chk("R4 masked bits ignored (110)", {31'd0, ok}, 32'd1);
      wr_byte(8'h00, ak);
      wr_byte(8'h40, ak);
      wr_byte(8'h9C, ak);
      bus_stop();
      poll_ready(t);
      set_ptr(16'h0040, ok);
      bus_start();
      wr_byte(8'hAF, a);
      chk("R4 masked bits ignored (111)", {31'd0, a}, 32'd1);
      rd_byte(1'b0, rbuf[0]);
      bus_stop();
      chk("R4 data via masked alias", {24'd0, rbuf[0]}, 32'h9C);
   endtask

   task automatic t_top_wrap();
      write_seq(16'h03FF, 8'h77, 8'h00, 8'h00, 8'h00, 1);
      write_seq(16'h0000, 8'h88, 8'h00, 8'h00, 8'h00, 1);
      read_from(16'h03FF, 2);
      chk("R9 top byte", {24'd0, rbuf[0]}, 32'h77);
      chk("R9 wrap to zero", {24'd0, rbuf[1]}, 32'h88);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_read();
      t_page_wrap();
      t_busy();
      t_no_busy();
      t_mismatch();
      t_mask();
      t_top_wrap();
      finish_run();
   end

endmodule